// File: doc/BRIEF.md
# Bus ROM Code Search Engine

This block sits on the master side of a single-wire, open-drain, wired-AND bus and discovers the 64-bit identity codes of the slaves attached to it. It does not time bus slots. Instead it drives a bit-level primitive through a request/done handshake with three operations: a bus reset that returns a presence flag, a single-bit write, and a single-bit read.

One `start` pulse runs a single search pass. The pass issues a bus reset and then writes the search opcode 0xF0. It then settles each of the 64 code positions in turn: it reads the bit that the remaining slaves drive, reads the complement of that bit, and writes back the value it chooses. Slaves whose bit differs from the written value drop out for the rest of the pass.

The engine keeps the position of the last unresolved branch from one pass to the next. Repeated passes therefore walk the whole tree of attached codes, one code per pass. A pass flags the final code when no branch remains open. After that flag, or after any failure, the next `start` begins a fresh enumeration.

Top module: `ow_search_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done` and `busReq` are low, and no request is made until `start` is seen.
- R2: Each pass begins with exactly one reset request (`busOp` = 0). If `busPresence` is low when that request completes, the pass ends with `noDevice` set and makes no further requests.
- R3: After presence, the engine issues eight write requests (`busOp` = 1) carrying the opcode 0xF0, least significant bit first (0,0,0,0,1,1,1,1).
- R4: For each code position, from bit 0 up to bit 63, the engine issues a read (`busOp` = 2) for the bit, a read for its complement, and then a write. It never raises `busReq` while an earlier request has not yet received `busDone`.
- R5: A read pair of (bit=0, complement=1) makes the engine write 0. A pair of (1, 0) makes it write 1.
- R6: A pair of (0, 0) is a branch. Below the previous pass's last branch position the engine repeats that pass's bit, at that position it writes 1, and above it it writes 0. Every branch resolved to 0 becomes the newest branch of the current pass. Positions are counted from 1 at bit 0.
- R7: A pair of (1, 1) aborts the pass with `searchErr` set, and no write follows.
- R8: When a pass completes, `done` pulses for one cycle and `romCode` holds the 64 written bits, with bit k equal to the k-th written code bit.
- R9: `lastDevice` is set with `done` when the pass recorded no branch resolved to 0. Successive passes return every attached code once, in ascending order of the bit-reversed code value.
- R10: After a pass that set `lastDevice`, `noDevice` or `searchErr`, the next `start` begins a new enumeration from the first code.
- R11: `start` is ignored while a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one search pass when idle |
| busReq | output | 1 | One-cycle request strobe to the bit primitive |
| busOp | output | 2 | Request kind: 0 reset, 1 write, 2 read |
| busWrBit | output | 1 | Bit to write, valid with a write request |
| busDone | input | 1 | Primitive completion strobe |
| busPresence | input | 1 | Presence flag, valid with busDone after a reset request |
| busRdBit | input | 1 | Sampled bus bit, valid with busDone after a read request |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass strobe |
| romCode | output | 64 | Code found by the last pass, bit 0 first on the bus |
| lastDevice | output | 1 | The pass just ended found the final code |
| noDevice | output | 1 | The pass ended because no presence was seen |
| searchErr | output | 1 | The pass ended because no slave answered a bit |

## Verification
The bench models four slaves whose codes share low-order prefixes, so branches appear at several depths. A design that mishandled the "repeat below, 1 at, 0 above" rule would return one code twice or skip one, and the comparison against a bit-reversed sort would catch it. A fifth pass after the final code checks that the enumeration restarts; a design that kept stale branch state would return the wrong first code or flag the end too early. Forced (1,1) answers in the middle of a pass and an absent presence check that the engine stops without writing and then recovers. An extra `start` in the middle of a pass checks that a design which restarted would break the request sequence, which is compared request by request.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;

  typedef enum logic [1:0] {
    BUS_RESET = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } busOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic beginPass;
    logic nextOpBit;
    logic latchId;
    logic latchCmp;
    logic commitBit;
    logic endPass;
    logic failSearch;
  } dpCtl_t;

endpackage

// File: rtl/ow_search_dp.sv
module ow_search_dp
  import ow_search_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC = 8'hF0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                busRdBit,
  output logic                opBit,
  output logic                dirBit,
  output logic                idBit,
  output logic                lastOpBit,
  output logic                lastRomBit,
  output logic [ROM_BITS-1:0] romCode,
  output logic                lastDevice
);

  localparam int IDX_W  = (ROM_BITS > 1) ? $clog2(ROM_BITS) : 1;
  localparam int DISC_W = $clog2(ROM_BITS + 1);
  localparam int OPI_W  = (OPC_W > 1) ? $clog2(OPC_W) : 1;

  logic [ROM_BITS-1:0] romReg;
  logic [IDX_W-1:0]    bitIdx;
  logic [OPI_W-1:0]    opIdx;
  logic                idReg, cmpReg;
  logic [DISC_W-1:0]   lastDisc, newDisc, discNow, pos;
  logic                restart, lastDevReg, dir, takeZero;

  assign pos        = DISC_W'(bitIdx) + DISC_W'(1);
  assign opBit      = OPC[opIdx];
  assign lastOpBit  = (opIdx == OPI_W'(OPC_W - 1));
  assign lastRomBit = (bitIdx == IDX_W'(ROM_BITS - 1));
  assign idBit      = idReg;
  assign dirBit     = dir;
  assign romCode    = romReg;
  assign lastDevice = lastDevReg;

  // branch decision
  always_comb begin
    unique case ({idReg, cmpReg})
      2'b01:   dir = 1'b0;
      2'b10:   dir = 1'b1;
      default: begin
        if (pos < lastDisc)       dir = romReg[bitIdx];
        else if (pos == lastDisc) dir = 1'b1;
        else                      dir = 1'b0;
      end
    endcase
    takeZero = !idReg && !cmpReg && !dir;
    discNow  = (ctl.commitBit && takeZero) ? pos : newDisc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romReg     <= '0;
      bitIdx     <= '0;
      opIdx      <= '0;
      idReg      <= 1'b0;
      cmpReg     <= 1'b0;
      lastDisc   <= '0;
      newDisc    <= '0;
      restart    <= 1'b1;
      lastDevReg <= 1'b0;
    end else begin
      if (ctl.beginPass) begin
        bitIdx     <= '0;
        opIdx      <= '0;
        newDisc    <= '0;
        lastDevReg <= 1'b0;
        if (restart) begin
          lastDisc <= '0;
          restart  <= 1'b0;
        end
      end
      if (ctl.nextOpBit) opIdx <= opIdx + OPI_W'(1);
      if (ctl.latchId)   idReg  <= busRdBit;
      if (ctl.latchCmp)  cmpReg <= busRdBit;
      if (ctl.commitBit) begin
        romReg[bitIdx] <= dir;
        newDisc        <= discNow;
        if (!lastRomBit) bitIdx <= bitIdx + IDX_W'(1);
      end
      if (ctl.endPass) begin
        lastDisc <= discNow;
        if (discNow == '0) begin
          lastDevReg <= 1'b1;
          restart    <= 1'b1;
        end
      end
      if (ctl.failSearch) restart <= 1'b1;
    end
  end

endmodule

// File: rtl/ow_search_ctl.sv
module ow_search_ctl
  import ow_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busDone,
  input  logic       busPresence,
  input  logic       busRdBit,
  input  logic       opBit,
  input  logic       dirBit,
  input  logic       idBit,
  input  logic       lastOpBit,
  input  logic       lastRomBit,
  output dpCtl_t     ctl,
  output logic       busReq,
  output logic [1:0] busOp,
  output logic       busWrBit,
  output logic       busy,
  output logic       done,
  output logic       noDevice,
  output logic       searchErr
);

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_OPC, S_RDID, S_RDCMP, S_WR, S_DONE
  } state_e;

  state_e state, nextState;
  logic   pend, nextPend;
  logic   setNoDev, setErr;

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_comb begin
    nextState = state;
    nextPend  = pend;
    ctl       = '0;
    busReq    = 1'b0;
    busOp     = BUS_READ;
    busWrBit  = 1'b0;
    setNoDev  = 1'b0;
    setErr    = 1'b0;
    unique case (state)
      S_RST:   busOp = BUS_RESET;
      S_OPC:   begin busOp = BUS_WRITE; busWrBit = opBit;  end
      S_WR:    begin busOp = BUS_WRITE; busWrBit = dirBit; end
      default: busOp = BUS_READ;
    endcase
    if (state == S_IDLE) begin
      if (start) begin
        ctl.beginPass = 1'b1;
        nextState     = S_RST;
      end
    end else if (state == S_DONE) begin
      nextState = S_IDLE;
    end else if (!pend) begin
      busReq   = 1'b1;
      nextPend = 1'b1;
    end else if (busDone) begin
      nextPend = 1'b0;
      unique case (state)
        S_RST: begin
          if (busPresence) nextState = S_OPC;
          else begin
            setNoDev       = 1'b1;
            ctl.failSearch = 1'b1;
            nextState      = S_DONE;
          end
        end
        S_OPC: begin
          ctl.nextOpBit = 1'b1;
          if (lastOpBit) nextState = S_RDID;
        end
        S_RDID: begin
          ctl.latchId = 1'b1;
          nextState   = S_RDCMP;
        end
        S_RDCMP: begin
          if (idBit && busRdBit) begin
            setErr         = 1'b1;
            ctl.failSearch = 1'b1;
            nextState      = S_DONE;
          end else begin
            ctl.latchCmp = 1'b1;
            nextState    = S_WR;
          end
        end
        S_WR: begin
          ctl.commitBit = 1'b1;
          if (lastRomBit) begin
            ctl.endPass = 1'b1;
            nextState   = S_DONE;
          end else begin
            nextState = S_RDID;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pend      <= 1'b0;
      noDevice  <= 1'b0;
      searchErr <= 1'b0;
    end else begin
      state <= nextState;
      pend  <= nextPend;
      if (ctl.beginPass) begin
        noDevice  <= 1'b0;
        searchErr <= 1'b0;
      end
      if (setNoDev) noDevice  <= 1'b1;
      if (setErr)   searchErr <= 1'b1;
    end
  end

endmodule

// File: rtl/ow_search_engine.sv
module ow_search_engine
  import ow_search_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC = 8'hF0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                busReq,
  output logic [1:0]          busOp,
  output logic                busWrBit,
  input  logic                busDone,
  input  logic                busPresence,
  input  logic                busRdBit,
  output logic                busy,
  output logic                done,
  output logic [ROM_BITS-1:0] romCode,
  output logic                lastDevice,
  output logic                noDevice,
  output logic                searchErr
);

  dpCtl_t ctl;
  logic   opBit, dirBit, idBit, lastOpBit, lastRomBit;

  ow_search_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .busDone(busDone), .busPresence(busPresence), .busRdBit(busRdBit),
    .opBit(opBit), .dirBit(dirBit), .idBit(idBit),
    .lastOpBit(lastOpBit), .lastRomBit(lastRomBit),
    .ctl(ctl), .busReq(busReq), .busOp(busOp), .busWrBit(busWrBit),
    .busy(busy), .done(done), .noDevice(noDevice), .searchErr(searchErr)
  );

  ow_search_dp #(.ROM_BITS(ROM_BITS), .OPC_W(OPC_W), .OPC(OPC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busRdBit(busRdBit),
    .opBit(opBit), .dirBit(dirBit), .idBit(idBit),
    .lastOpBit(lastOpBit), .lastRomBit(lastRomBit),
    .romCode(romCode), .lastDevice(lastDevice)
  );

endmodule

// File: rtl/ow_search_chk.sv
module ow_search_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busDone,
  input logic busy,
  input logic done,
  input logic lastDevice,
  input logic noDevice,
  input logic searchErr
);

  logic outst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outst <= 1'b0;
    else if (busReq)  outst <= 1'b1;
    else if (busDone) outst <= 1'b0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  p_single_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !outst);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_status_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot0({noDevice, searchErr, lastDevice}));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind ow_search_engine ow_search_chk u_chk (.*);

// File: tb/ow_search_engine_test.sv
module ow_search_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busReq;
  logic [1:0]  busOp;
  logic        busWrBit;
  logic        busDone = 1'b0;
  logic        busPresence = 1'b0;
  logic        busRdBit = 1'b0;
  logic        busy, done, lastDevice, noDevice, searchErr;
  logic [63:0] romCode;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // slave population model
  logic [63:0] devs [4];
  logic [63:0] sorted [4];
  int          nDev = 0;
  logic [3:0]  act;
  int          reqIdx = 0;
  int          killBit = -1;
  logic [63:0] expCode = '0;
  int          cnt = 0;
  logic        rdNext, presNext;
  logic        idSeen;

  localparam logic [7:0] OPC = 8'hF0;

  ow_search_engine uut (
    .clk(clk), .rstN(rstN), .start(start),
    .busReq(busReq), .busOp(busOp), .busWrBit(busWrBit),
    .busDone(busDone), .busPresence(busPresence), .busRdBit(busRdBit),
    .busy(busy), .done(done), .romCode(romCode),
    .lastDevice(lastDevice), .noDevice(noDevice), .searchErr(searchErr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act_v,
                       input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] v);
    for (int i = 0; i < 64; i++) rev64[i] = v[63-i];
  endfunction

  task automatic setDevices(input int n);
    logic [63:0] t;
    nDev = n;
    for (int i = 0; i < n; i++) sorted[i] = devs[i];
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++)
        if (rev64(sorted[j]) < rev64(sorted[i])) begin
          t = sorted[i]; sorted[i] = sorted[j]; sorted[j] = t;
        end
  endtask

  // bit-level primitive and slaves, compared per request
  always @(posedge clk) begin
    busDone <= 1'b0;
    if (cnt == 1) begin
      busDone     <= 1'b1;
      busRdBit    <= rdNext;
      busPresence <= presNext;
      cnt         <= 0;
    end else if (cnt > 1) begin
      cnt <= cnt - 1;
    end
    if (rstN && busReq) begin
      check(cnt == 0 && !busDone, "R4 overlap", 64'(cnt), 64'd0);
      cnt <= 2;
      if (reqIdx == 0) begin
        check(busOp == 2'd0, "R2 reset first", 64'(busOp), 64'd0);
        act      = (nDev == 0) ? 4'b0 : 4'((1 << nDev) - 1);
        presNext = (nDev != 0);
      end else if (reqIdx <= 8) begin
        check(busOp == 2'd1, "R3 opcode op", 64'(busOp), 64'd1);
        check(busWrBit == OPC[reqIdx-1], "R3 opcode bit", 64'(busWrBit),
              64'(OPC[reqIdx-1]));
      end else begin
        automatic int b = (reqIdx - 9) / 3;
        automatic int ph = (reqIdx - 9) % 3;
        if (ph < 2) begin
          check(busOp == 2'd2, "R4 read op", 64'(busOp), 64'd2);
          if (b == killBit) act = 4'b0;
          rdNext = 1'b1;
          for (int i = 0; i < nDev; i++)
            if (act[i]) rdNext = rdNext & (devs[i][b] ^ (ph == 1));
          if (ph == 0) idSeen = rdNext;
        end else begin
          check(busOp == 2'd1, "R4 write op", 64'(busOp), 64'd1);
          check(busWrBit == expCode[b], "R5 R6 write bit", 64'(busWrBit),
                64'(expCode[b]));
          for (int i = 0; i < nDev; i++)
            if (devs[i][b] != busWrBit) act[i] = 1'b0;
        end
      end
      reqIdx = reqIdx + 1;
    end
  end

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin
      fails++;
      $display("FAIL watchdog: actual no done expected done");
    end
  endtask

  task automatic runPass(input logic [63:0] code, input bit expLast,
                         input bit expNoDev, input bit expErr,
                         input bit midStart, input string tag);
    bit ok;
    expCode = code;
    reqIdx  = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStart) begin
      repeat (30) @(negedge clk);
      start = 1'b1;                 // R11: must be ignored
      @(negedge clk); start = 1'b0;
    end
    waitDone(ok);
    if (!ok) return;
    check(noDevice == expNoDev, {tag, " R2 noDevice"}, 64'(noDevice), 64'(expNoDev));
    check(searchErr == expErr, {tag, " R7 searchErr"}, 64'(searchErr), 64'(expErr));
    if (!expNoDev && !expErr) begin
      check(romCode == code, {tag, " R8 R9 romCode"}, romCode, code);
      check(lastDevice == expLast, {tag, " R9 lastDevice"}, 64'(lastDevice),
            64'(expLast));
    end
    @(negedge clk);
    check(!done, {tag, " R8 done pulse"}, 64'(done), 64'd0);
    repeat (4) @(negedge clk);
    if (expNoDev)
      check(reqIdx == 1, {tag, " R2 no further requests"}, 64'(reqIdx), 64'd1);
    if (expErr)
      check(reqIdx == 9 + 3 * killBit + 2, {tag, " R7 no write after abort"},
            64'(reqIdx), 64'(9 + 3 * killBit + 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !busReq, "R1 reset state",
          64'({busy, done, busReq}), 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !busReq, "R1 idle without start", 64'({busy, busReq}), 64'd0);

    // four slaves sharing low-order prefixes
    devs[0] = 64'h1122_3344_5566_7701;
    devs[1] = 64'h1122_3344_5566_7703;
    devs[2] = 64'hA0B0_C0D0_E0F0_1001;
    devs[3] = 64'h0F0E_0D0C_0B0A_0905;
    setDevices(4);
    for (int k = 0; k < 4; k++)
      runPass(sorted[k], k == 3, 0, 0, k == 1, "enum R6");
    runPass(sorted[0], 0, 0, 0, 0, "restart R10");

    // single slave
    devs[0] = 64'hDEAD_BEEF_0123_4567;
    setDevices(1);
    runPass(sorted[0], 1, 0, 0, 0, "single R5");

    // no slave present
    setDevices(0);
    runPass(64'd0, 0, 1, 0, 0, "empty R2");

    // mid-pass loss of all slaves, then recovery
    devs[0] = 64'h0000_0000_0000_0010;
    devs[1] = 64'h0000_0000_0000_0011;
    devs[2] = 64'h8000_0000_0000_0012;
    setDevices(3);
    runPass(sorted[0], 0, 0, 0, 0, "err-pre R9");
    killBit = 20;
    runPass(sorted[1], 0, 0, 1, 0, "abort R7");
    killBit = -1;
    runPass(sorted[0], 0, 0, 0, 0, "after-err R10");
    runPass(sorted[1], 0, 0, 0, 0, "cont R6");
    runPass(sorted[2], 1, 0, 0, 0, "final R9");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule